// File: doc/BRIEF.md
# Command Stream Method Decoder

This block sits behind the word fetcher of a graphics command processor. It receives a stream of 32-bit command words and turns it into individual method calls. Each call carries a subchannel number, a method address counted in 32-bit word units, an argument and a last-of-header marker. A header word sets the method address, the subchannel, an argument count and a submission mode. The data words that follow supply the arguments. In one of the modes the argument sits in the header itself.

Each call goes to one of two ports, chosen by its method address. Addresses below 0x40 go to a local control port. All other addresses go to an engine port, which carries the subchannel so that downstream logic can pick one of eight engines. Both ports and the input use valid/ready handshakes. A call passes straight through from the input word to the selected port, so a stalled port holds the input word in place. A segment-start flag on an input word forces a fresh header decode.

Top module: `cmdsd_top`

## Requirements
- R1: In a header word, bits 12:0 are the method address, bits 15:13 the subchannel, bits 28:16 the argument count and bits 31:29 the mode. In modes 0 and 1 the data words that follow become calls whose address starts at the header's method and rises by one per word, modulo 2^13.
- R2: In modes 2 and 3, every data word of the header becomes a call to the header's method address.
- R3: In mode 4, the header alone makes one call to its method and subchannel. The argument is bits 28:16 zero-extended to 32 bits, the last flag is 1, and the next word is decoded as a header.
- R4: In mode 5, the first data word goes to the header's method and every later data word goes to method+1.
- R5: A call whose address is below 0x40 appears only on the control port. Any other call appears only on the engine port, with the header's subchannel. At most one port is valid in a cycle, and the port is chosen per call.
- R6: A header in mode 0, 1, 2, 3 or 5 with an argument count of 0 makes no call, and the next word is decoded as a header.
- R7: A header in mode 6 or 7 makes no call and sets `err_mode`, which stays at 1 until reset. The next word is decoded as a header.
- R8: The call made from the final data word of a header has the last flag at 1. Every earlier call of that header has it at 0.
- R9: A word that produces a call is accepted (`in_ready` = 1) only in a cycle where the selected port is ready. A header that produces no call is always accepted. A stall loses no state.
- R10: A word with `in_seg` = 1 is decoded as a header even when arguments are still pending. The pending arguments are discarded.
- R11: After reset, no port is valid, `err_mode` is 0 and the first word is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle |
| in_word | input | 32 | Command word |
| in_seg | input | 1 | Segment start: decode this word as a header |
| eng_valid | output | 1 | Engine call valid |
| eng_ready | input | 1 | Engine call taken |
| eng_subch | output | 3 | Subchannel of the engine call |
| eng_method | output | 13 | Method address of the engine call |
| eng_arg | output | 32 | Argument of the engine call |
| eng_last | output | 1 | Final call of its header |
| ctl_valid | output | 1 | Control call valid |
| ctl_ready | input | 1 | Control call taken |
| ctl_method | output | 13 | Method address of the control call |
| ctl_arg | output | 32 | Argument of the control call |
| ctl_last | output | 1 | Final call of its header |
| err_mode | output | 1 | Sticky flag for a header with mode 6 or 7 |

## Verification
Two functions can fall in the same cycle. A segment-start header can arrive while arguments are still pending. A stepping header can also carry its address across the 0x40 boundary while the port it moves to is stalled, which makes the port switch and the backpressure stall coincide. The stimulus sets the segment flag in the middle of a header's data. It also drives a header at 0x3D with random ready patterns on both ports. A behavioural model in the bench predicts every output port and `in_ready` in every cycle, and the bench compares them in that cycle.

// File: rtl/cmdsd_pkg.sv
package cmdsd_pkg;
  localparam int WORD_W  = 32;
  localparam int METH_W  = 13;
  localparam int SUB_W   = 3;
  localparam int CNT_W   = 13;
  localparam int MODE_W  = 3;
  localparam int SUB_LSB = METH_W;
  localparam int CNT_LSB = METH_W + SUB_W;
  localparam int MODE_LSB = CNT_LSB + CNT_W;

  typedef enum logic [2:0] {
    K_INC    = 3'd0,
    K_NONINC = 3'd1,
    K_INLINE = 3'd2,
    K_ONCE   = 3'd3,
    K_BAD    = 3'd4
  } kind_e;

  typedef struct packed {
    logic [METH_W-1:0] meth;
    logic [SUB_W-1:0]  sub;
    logic [CNT_W-1:0]  cnt;
    kind_e             kind;
  } hdr_t;

  function automatic kind_e mode_kind(input logic [MODE_W-1:0] m);
    case (m)
      3'd0, 3'd1: mode_kind = K_INC;
      3'd2, 3'd3: mode_kind = K_NONINC;
      3'd4:       mode_kind = K_INLINE;
      3'd5:       mode_kind = K_ONCE;
      default:    mode_kind = K_BAD;
    endcase
  endfunction
endpackage

// File: rtl/cmdsd_rst_sync.sv
module cmdsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cmdsd_hdr_decode.sv
module cmdsd_hdr_decode
  import cmdsd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_t              hdr
);
  always_comb begin
    hdr.meth = word[METH_W-1:0];
    hdr.sub  = word[SUB_LSB +: SUB_W];
    hdr.cnt  = word[CNT_LSB +: CNT_W];
    hdr.kind = mode_kind(word[MODE_LSB +: MODE_W]);
  end
endmodule

// File: rtl/cmdsd_seq.sv
module cmdsd_seq
  import cmdsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_seg,
  input  logic [WORD_W-1:0] in_word,
  input  hdr_t              hdr,
  input  logic              sel_ready,
  output logic              in_ready,
  output logic              call_valid,
  output logic [METH_W-1:0] call_meth,
  output logic [SUB_W-1:0]  call_sub,
  output logic [WORD_W-1:0] call_arg,
  output logic              call_last,
  output logic              err_mode
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [METH_W-1:0] meth_q, meth_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  kind_e             kind_q, kind_d;
  logic              first_q, first_d;
  logic              err_q, err_d;

  logic data_phase, hdr_call, call_gen, accept;

  // call generation
  always_comb begin
    data_phase = (cnt_q != '0) && !in_seg;
    hdr_call   = !data_phase && (hdr.kind == K_INLINE);
    call_gen   = data_phase || hdr_call;
    call_valid = in_valid && call_gen;
    if (data_phase) begin
      call_meth = meth_q;
      call_sub  = sub_q;
      call_arg  = in_word;
      call_last = (cnt_q == CNT_W'(1));
    end else begin
      call_meth = hdr.meth;
      call_sub  = hdr.sub;
      call_arg  = {{(WORD_W-CNT_W){1'b0}}, hdr.cnt};
      call_last = 1'b1;
    end
    in_ready = call_gen ? sel_ready : 1'b1;
    accept   = in_valid && in_ready;
  end

  // next state
  always_comb begin
    cnt_d   = cnt_q;
    meth_d  = meth_q;
    sub_d   = sub_q;
    kind_d  = kind_q;
    first_d = first_q;
    err_d   = err_q;
    if (data_phase) begin
      cnt_d = cnt_q - CNT_W'(1);
      case (kind_q)
        K_INC:  meth_d = meth_q + METH_W'(1);
        K_ONCE: begin
          if (first_q) meth_d = meth_q + METH_W'(1);
          first_d = 1'b0;
        end
        default: meth_d = meth_q;
      endcase
    end else begin
      case (hdr.kind)
        K_BAD: begin
          cnt_d = '0;
          err_d = 1'b1;
        end
        K_INLINE: cnt_d = '0;
        default: begin
          cnt_d   = hdr.cnt;
          meth_d  = hdr.meth;
          sub_d   = hdr.sub;
          kind_d  = hdr.kind;
          first_d = 1'b1;
        end
      endcase
    end
  end

  // registers, enabled by word acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      meth_q  <= '0;
      sub_q   <= '0;
      kind_q  <= K_INC;
      first_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (accept) begin
      cnt_q   <= cnt_d;
      meth_q  <= meth_d;
      sub_q   <= sub_d;
      kind_q  <= kind_d;
      first_q <= first_d;
      err_q   <= err_d;
    end
  end

  assign err_mode = err_q;
endmodule

// File: rtl/cmdsd_route.sv
module cmdsd_route
  import cmdsd_pkg::*;
#(
  parameter int CTL_LIMIT = 64
) (
  input  logic              call_valid,
  input  logic [METH_W-1:0] call_meth,
  input  logic [SUB_W-1:0]  call_sub,
  input  logic [WORD_W-1:0] call_arg,
  input  logic              call_last,
  input  logic              eng_ready,
  input  logic              ctl_ready,
  output logic              sel_ready,
  output logic              eng_valid,
  output logic [SUB_W-1:0]  eng_subch,
  output logic [METH_W-1:0] eng_method,
  output logic [WORD_W-1:0] eng_arg,
  output logic              eng_last,
  output logic              ctl_valid,
  output logic [METH_W-1:0] ctl_method,
  output logic [WORD_W-1:0] ctl_arg,
  output logic              ctl_last
);
  localparam logic [METH_W-1:0] LIMIT = METH_W'(CTL_LIMIT);

  logic is_ctl;

  always_comb begin
    is_ctl     = (call_meth < LIMIT);
    sel_ready  = is_ctl ? ctl_ready : eng_ready;
    ctl_valid  = call_valid && is_ctl;
    eng_valid  = call_valid && !is_ctl;
    ctl_method = call_meth;
    ctl_arg    = call_arg;
    ctl_last   = call_last;
    eng_method = call_meth;
    eng_subch  = call_sub;
    eng_arg    = call_arg;
    eng_last   = call_last;
  end
endmodule

// File: rtl/cmdsd_top.sv
module cmdsd_top
  import cmdsd_pkg::*;
#(
  parameter int CTL_LIMIT = 64,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_seg,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [SUB_W-1:0]  eng_subch,
  output logic [METH_W-1:0] eng_method,
  output logic [WORD_W-1:0] eng_arg,
  output logic              eng_last,
  output logic              ctl_valid,
  input  logic              ctl_ready,
  output logic [METH_W-1:0] ctl_method,
  output logic [WORD_W-1:0] ctl_arg,
  output logic              ctl_last,
  output logic              err_mode
);
  logic              rst_n_int;
  hdr_t              hdr;
  logic              sel_ready;
  logic              call_valid;
  logic [METH_W-1:0] call_meth;
  logic [SUB_W-1:0]  call_sub;
  logic [WORD_W-1:0] call_arg;
  logic              call_last;

  cmdsd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  cmdsd_hdr_decode u_dec (.word(in_word), .hdr(hdr));

  cmdsd_seq u_seq (
    .clk(clk), .rst_n(rst_n_int), .in_valid(in_valid), .in_seg(in_seg),
    .in_word(in_word), .hdr(hdr), .sel_ready(sel_ready),
    .in_ready(in_ready), .call_valid(call_valid), .call_meth(call_meth),
    .call_sub(call_sub), .call_arg(call_arg), .call_last(call_last),
    .err_mode(err_mode)
  );

  cmdsd_route #(.CTL_LIMIT(CTL_LIMIT)) u_route (
    .call_valid(call_valid), .call_meth(call_meth), .call_sub(call_sub),
    .call_arg(call_arg), .call_last(call_last),
    .eng_ready(eng_ready), .ctl_ready(ctl_ready), .sel_ready(sel_ready),
    .eng_valid(eng_valid), .eng_subch(eng_subch), .eng_method(eng_method),
    .eng_arg(eng_arg), .eng_last(eng_last),
    .ctl_valid(ctl_valid), .ctl_method(ctl_method), .ctl_arg(ctl_arg),
    .ctl_last(ctl_last)
  );
endmodule

// File: rtl/cmdsd_checker.sv
module cmdsd_checker
  import cmdsd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              eng_valid,
  input logic              eng_ready,
  input logic [METH_W-1:0] eng_method,
  input logic              ctl_valid,
  input logic              ctl_ready,
  input logic [METH_W-1:0] ctl_method,
  input logic              err_mode
);
  // R5: control port only below the threshold
  a_r5_ctl_range: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> (ctl_method < METH_W'(64)));

  // R5: engine port only at or above the threshold
  a_r5_eng_range: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> (eng_method >= METH_W'(64)));

  // R5: never both ports in one cycle
  a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_valid && ctl_valid));

  // R7: error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |=> err_mode);

  // R9: input stalls only behind a stalled call
  a_r9_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> ((eng_valid && !eng_ready) || (ctl_valid && !ctl_ready)));
endmodule

bind cmdsd_top cmdsd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_method(eng_method),
  .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_method(ctl_method),
  .err_mode(err_mode)
);

// File: tb/cmdsd_top_bench.sv
`timescale 1ns/100ps
module cmdsd_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_seg;
  logic [31:0] in_word;
  logic        eng_valid, eng_ready, eng_last;
  logic [2:0]  eng_subch;
  logic [12:0] eng_method;
  logic [31:0] eng_arg;
  logic        ctl_valid, ctl_ready, ctl_last;
  logic [12:0] ctl_method;
  logic [31:0] ctl_arg;
  logic        err_mode;

  always #2.5 clk = ~clk;

  cmdsd_top u_cmdsd_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_seg(in_seg),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_subch(eng_subch),
    .eng_method(eng_method), .eng_arg(eng_arg), .eng_last(eng_last),
    .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_method(ctl_method),
    .ctl_arg(ctl_arg), .ctl_last(ctl_last), .err_mode(err_mode)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit run   = 0;
  bit acc_last = 0;

  logic [31:0] w_q[$];
  bit          s_q[$];
  string       t_q[$];
  string       cur_tag = "R11";

  // model state
  int          m_cnt = 0;
  logic [12:0] m_meth = '0;
  logic [2:0]  m_sub = '0;
  int          m_mode = 1;
  bit          m_first = 0;
  bit          m_err = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input int mode, input int cnt, input int sub, input int meth);
    return {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
  endfunction

  task automatic push(input logic [31:0] w, input bit s, input string t);
    w_q.push_back(w); s_q.push_back(s); t_q.push_back(t);
  endtask

  // cycle reference model and comparison
  always @(negedge clk) begin
    if (run && !done) begin
      bit dp, gen, lst, e_ctl, e_eng, e_rdy, acc;
      logic [12:0] m; logic [2:0] s; logic [31:0] a;
      int md;
      dp = (m_cnt != 0) && !in_seg;
      md = int'(in_word[31:29]);
      gen = 0; m = '0; s = '0; a = '0; lst = 0;
      if (dp) begin
        gen = 1; m = m_meth; s = m_sub; a = in_word; lst = (m_cnt == 1);
      end else if (md == 4) begin
        gen = 1; m = in_word[12:0]; s = in_word[15:13];
        a = {19'b0, in_word[28:16]}; lst = 1;
      end
      e_ctl = in_valid && gen && (m < 13'd64);
      e_eng = in_valid && gen && (m >= 13'd64);
      e_rdy = !gen || ((m < 13'd64) ? ctl_ready : eng_ready);
      chk(ctl_valid == e_ctl, cur_tag, "ctl_valid", 32'(ctl_valid), 32'(e_ctl));
      chk(eng_valid == e_eng, cur_tag, "eng_valid", 32'(eng_valid), 32'(e_eng));
      chk(in_ready == e_rdy, cur_tag, "in_ready", 32'(in_ready), 32'(e_rdy));
      chk(err_mode == m_err, cur_tag, "err_mode", 32'(err_mode), 32'(m_err));
      if (e_ctl) begin
        chk(ctl_method == m, cur_tag, "ctl_method", 32'(ctl_method), 32'(m));
        chk(ctl_arg == a, cur_tag, "ctl_arg", ctl_arg, a);
        chk(ctl_last == lst, cur_tag, "ctl_last", 32'(ctl_last), 32'(lst));
      end
      if (e_eng) begin
        chk(eng_method == m, cur_tag, "eng_method", 32'(eng_method), 32'(m));
        chk(eng_subch == s, cur_tag, "eng_subch", 32'(eng_subch), 32'(s));
        chk(eng_arg == a, cur_tag, "eng_arg", eng_arg, a);
        chk(eng_last == lst, cur_tag, "eng_last", 32'(eng_last), 32'(lst));
      end
      acc = in_valid && e_rdy;
      acc_last = acc;
      if (acc) begin
        if (dp) begin
          m_cnt--;
          if (m_mode <= 1) m_meth = m_meth + 13'd1;
          else if (m_mode == 5) begin
            if (m_first) m_meth = m_meth + 13'd1;
            m_first = 0;
          end
        end else if (md >= 6) begin
          m_cnt = 0; m_err = 1;
        end else if (md == 4) begin
          m_cnt = 0;
        end else begin
          m_cnt = int'(in_word[28:16]); m_meth = in_word[12:0];
          m_sub = in_word[15:13]; m_mode = md; m_first = 1;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: increasing modes
    push(hdr(1, 3, 2, 'h100), 0, "R1");
    push(32'hA0000001, 0, "R1"); push(32'hA0000002, 0, "R1"); push(32'hA0000003, 0, "R1");
    push(hdr(0, 2, 4, 'h1FFF), 0, "R1");
    push(32'hB1, 0, "R1"); push(32'hB2, 0, "R1");
    // R2: non-increasing modes
    push(hdr(3, 3, 1, 'h80), 0, "R2");
    push(32'hC1, 0, "R2"); push(32'hC2, 0, "R2"); push(32'hC3, 0, "R2");
    push(hdr(2, 2, 0, 'h10), 0, "R2");
    push(32'hC4, 0, "R2"); push(32'hC5, 0, "R2");
    // R3: inline
    push(hdr(4, 'h1ABC, 3, 'h60), 0, "R3");
    push(hdr(4, 'h0005, 0, 'h05), 0, "R3");
    // R4: increase-once
    push(hdr(5, 4, 5, 'h70), 0, "R4");
    push(32'hD1, 0, "R4"); push(32'hD2, 0, "R4"); push(32'hD3, 0, "R4"); push(32'hD4, 0, "R4");
    // R5: boundary crossing per call
    push(hdr(1, 3, 6, 'h3E), 0, "R5");
    push(32'hE1, 0, "R5"); push(32'hE2, 0, "R5"); push(32'hE3, 0, "R5");
    // R6: zero count
    push(hdr(1, 0, 1, 'h120), 0, "R6");
    push(hdr(4, 7, 1, 'h120), 0, "R6");
    // R8: single data word is last
    push(hdr(3, 1, 5, 'h45), 0, "R8");
    push(32'hF1, 0, "R8");
    // R10: segment start mid-header
    push(hdr(1, 5, 2, 'h200), 0, "R10");
    push(32'h11, 0, "R10"); push(32'h12, 0, "R10");
    push(hdr(3, 1, 7, 'h90), 1, "R10");
    push(32'h13, 0, "R10");
    push(hdr(1, 2, 3, 'h300), 0, "R10");
    push(32'h14, 1, "R10");
    // R9: backpressure mix
    push(hdr(1, 4, 7, 'h3D), 0, "R9");
    for (int i = 0; i < 4; i++) push(32'h900 + 32'(i), 0, "R9");
    push(hdr(5, 3, 6, 'h41), 0, "R9");
    for (int i = 0; i < 3; i++) push(32'h910 + 32'(i), 0, "R9");
    push(hdr(4, 'h55, 0, 'h10), 0, "R9");
    push(hdr(4, 'h66, 2, 'h400), 0, "R9");
    push(hdr(3, 6, 4, 'h22), 0, "R9");
    for (int i = 0; i < 6; i++) push(32'h920 + 32'(i), 0, "R9");
    // R7: illegal modes, then normal traffic
    push(hdr(6, 2, 0, 'h50), 0, "R7");
    push(hdr(7, 3, 0, 'h51), 0, "R7");
    push(hdr(1, 1, 0, 'h44), 0, "R7");
    push(32'h77, 0, "R7");

    rst_n = 1'b0; in_valid = 0; in_word = '0; in_seg = 0;
    eng_ready = 1; ctl_ready = 1;
    repeat (3) begin
      @(negedge clk);
      chk(!eng_valid && !ctl_valid, "R11", "valid in reset", 32'({eng_valid, ctl_valid}), 32'h0);
      chk(err_mode == 1'b0, "R11", "err in reset", 32'(err_mode), 32'h0);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 run = 1;
    forever begin
      @(posedge clk); #1;
      if (acc_last) begin
        void'(w_q.pop_front()); void'(s_q.pop_front()); void'(t_q.pop_front());
      end
      if (w_q.size() == 0) break;
      cur_tag = t_q[0];
      in_word = w_q[0];
      in_seg  = s_q[0];
      if (cur_tag == "R9") begin
        in_valid  = ($urandom % 4) != 0;
        eng_ready = $urandom % 2;
        ctl_ready = $urandom % 2;
      end else begin
        in_valid = 1; eng_ready = 1; ctl_ready = 1;
      end
    end
    in_valid = 0; in_seg = 0; cur_tag = "R7";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(err_mode == 1'b1, "R7", "err sticky at end", 32'(err_mode), 32'h1);
    chk(!eng_valid && !ctl_valid, "R6", "idle after stream", 32'({eng_valid, ctl_valid}), 32'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule